// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder

This block adds or subtracts two single-precision binary floating-point values. The format has a sign bit, an 8-bit exponent biased by 127 and a 23-bit fraction with an implied leading one. The block is a three-stage pipeline and accepts one operand pair in every clock cycle. The first stage swaps the operands so the larger magnitude comes first, then right-shifts the smaller significand until the exponents match. The second stage adds or subtracts the two aligned significands. The third stage normalizes the result, catches exponent overflow and underflow, and packs the result word together with a status flag vector.

A caller drives `a_i`, `b_i` and `sub_i` with `valid_i` high. When `sub_i` is set, the block computes `a - b` by flipping the sign of `b` before alignment. Exponent-zero operands count as zero, so denormals are not supported. Bits shifted out past three guard positions are discarded, and the result is truncated toward zero with no rounding.

Top module: `fp_add_pipe`

## Requirements
- R1: When `valid_i` is high at a rising edge, `valid_o` is high with the matching result after the third rising edge, counting that edge as the first. A new operand pair may enter on every cycle, and results leave in the order the pairs entered. `valid_o` is low in any cycle that received no operand.
- R2: For two finite nonzero operands with the same effective sign, the result is the exact sum truncated toward zero to 24 significant bits. For example, 0x3F800000 + 0x33C00000 gives 0x3F800000.
- R3: With `sub_i` high, the result equals the sum of `a_i` and `b_i` with the sign bit of `b_i` inverted. Examples: 0 - 1.0 gives 0xBF800000, and 3.0 - 1.0 gives 0x40000000.
- R4: The operand with the smaller magnitude is aligned to the larger exponent. An operand more than 26 binary places below the other leaves the larger operand unchanged.
- R5: When the significand sum reaches 2.0 or more, the result is shifted right by one place and its exponent is raised by one. Example: 0x3FFFFFFF + 0x3F800000 gives 0x403FFFFF.
- R6: When cancellation leaves the significand below 1.0, the result is shifted left until the leading one is back in place, and the exponent is lowered by the same count. Example: 1.5 - 1.25 gives 0x3E800000.
- R7: A result whose significand is exactly zero is encoded as +0 (0x00000000), with flag bit 3 (zero) set.
- R8: If either operand has exponent 0xFF and a nonzero fraction, the result is 0x7FC00000 with flag bit 0 (invalid) set.
- R9: An infinite operand (exponent 0xFF, fraction 0) yields an infinity of that operand's effective sign, with no flags set. Two infinities of opposite effective sign yield 0x7FC00000 with flag bit 0 set.
- R10: A normalized exponent of 255 or more gives an infinity with the sign of the result, with flag bit 1 (overflow) set.
- R11: A normalized exponent of 0 or less on a nonzero significand gives 0x00000000, with only flag bit 2 (underflow) set.
- R12: An operand with exponent field 0 is treated as zero, whatever its fraction.
- R13: While `rst_ni` is low, and after reset until the first result is due, `valid_o`, `res_o` and `flags_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair present |
| sub_i | input | 1 | 1 selects a - b, 0 selects a + b |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| valid_o | output | 1 | Result present |
| res_o | output | 32 | Result word |
| flags_o | output | 4 | bit0 invalid, bit1 overflow, bit2 underflow, bit3 zero |

## Verification
Every result is due three rising edges after the edge that captures its operands. Each directed task drives its operands on a falling edge and drops `valid_i` one falling edge later. It then waits two more falling edges and samples `res_o`, `flags_o` and `valid_o` there, which is half a period after the third register stage loads. The streaming task issues three back-to-back pairs. It checks that `valid_o` is still low one cycle before the first result is due, then expects the three results on three consecutive falling edges, followed by an empty cycle.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int FLAG_W  = 4;
  localparam int FL_NAN  = 0;
  localparam int FL_OVF  = 1;
  localparam int FL_UF   = 2;
  localparam int FL_ZERO = 3;

  typedef struct packed {
    logic nan;
    logic inf;
    logic inf_sgn;
  } fpa_spec_t;
endpackage

// File: rtl/fpa_align.sv
module fpa_align
  import fpa_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int GRD_W = 3,
  localparam int DW    = EXP_W + MAN_W + 1,
  localparam int SIG_W = MAN_W + 1 + GRD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sub_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  output logic             vld_o,
  output logic             sgn_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0] big_o,
  output logic [SIG_W-1:0] sml_o,
  output logic             eff_sub_o,
  output fpa_spec_t        spec_o
);
  localparam logic [EXP_W-1:0] SIG_W_E = EXP_W'(SIG_W);

  logic [EXP_W-1:0] a_e, b_e, big_e, sml_e, diff;
  logic [MAN_W-1:0] a_f, b_f;
  logic             a_s, b_s, a_z, b_z;
  logic             a_max, b_max, a_nan, b_nan, a_inf, b_inf;
  logic [DW-2:0]    mag_a, mag_b;
  logic             a_big;
  logic [SIG_W-1:0] a_sig, b_sig, big_sig, sml_sig, sml_sh;
  fpa_spec_t        spec_d;

  always_comb begin
    a_e   = a_i[DW-2 -: EXP_W];
    b_e   = b_i[DW-2 -: EXP_W];
    a_f   = a_i[MAN_W-1:0];
    b_f   = b_i[MAN_W-1:0];
    a_s   = a_i[DW-1];
    b_s   = b_i[DW-1] ^ sub_i;          // subtraction folds into b's sign
    a_z   = (a_e == '0);                // exponent zero: treated as zero
    b_z   = (b_e == '0);
    a_max = &a_e;
    b_max = &b_e;
    a_nan = a_max && (|a_f);
    b_nan = b_max && (|b_f);
    a_inf = a_max && !(|a_f);
    b_inf = b_max && !(|b_f);

    mag_a = a_z ? '0 : a_i[DW-2:0];
    mag_b = b_z ? '0 : b_i[DW-2:0];
    a_big = (mag_a >= mag_b);

    a_sig = a_z ? '0 : {1'b1, a_f, {GRD_W{1'b0}}};
    b_sig = b_z ? '0 : {1'b1, b_f, {GRD_W{1'b0}}};

    big_e   = a_big ? a_e : b_e;
    sml_e   = a_big ? b_e : a_e;
    big_sig = a_big ? a_sig : b_sig;
    sml_sig = a_big ? b_sig : a_sig;
    diff    = big_e - sml_e;
    sml_sh  = (diff >= SIG_W_E) ? '0 : (sml_sig >> diff);

    spec_d.nan     = a_nan || b_nan || (a_inf && b_inf && (a_s != b_s));
    spec_d.inf     = (a_inf || b_inf) && !spec_d.nan;
    spec_d.inf_sgn = a_inf ? a_s : b_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o     <= 1'b0;
      sgn_o     <= 1'b0;
      exp_o     <= '0;
      big_o     <= '0;
      sml_o     <= '0;
      eff_sub_o <= 1'b0;
      spec_o    <= '0;
    end else begin
      vld_o     <= valid_i;
      sgn_o     <= a_big ? a_s : b_s;
      exp_o     <= big_e;
      big_o     <= big_sig;
      sml_o     <= sml_sh;
      eff_sub_o <= a_s ^ b_s;
      spec_o    <= spec_d;
    end
  end

  // R8: a NaN-coded first operand is flagged one stage later
  p_nan_in_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (&a_i[DW-2 -: EXP_W]) && (|a_i[MAN_W-1:0])) |=> spec_o.nan);
endmodule

// File: rtl/fpa_addsub.sv
module fpa_addsub
  import fpa_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int GRD_W = 3,
  localparam int SIG_W = MAN_W + 1 + GRD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             sgn_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] big_i,
  input  logic [SIG_W-1:0] sml_i,
  input  logic             eff_sub_i,
  input  fpa_spec_t        spec_i,
  output logic             vld_o,
  output logic             sgn_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [SIG_W:0]   sum_o,
  output fpa_spec_t        spec_o
);
  logic [SIG_W:0] sum_d;

  always_comb begin
    if (eff_sub_i) sum_d = {1'b0, big_i} - {1'b0, sml_i};
    else           sum_d = {1'b0, big_i} + {1'b0, sml_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      sgn_o  <= 1'b0;
      exp_o  <= '0;
      sum_o  <= '0;
      spec_o <= '0;
    end else begin
      vld_o  <= vld_i;
      sgn_o  <= sgn_i;
      exp_o  <= exp_i;
      sum_o  <= sum_d;
      spec_o <= spec_i;
    end
  end

  // R6: alignment must hand over the larger magnitude first, so no borrow
  p_no_borrow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && eff_sub_i) |-> (big_i >= sml_i));
endmodule

// File: rtl/fpa_norm.sv
module fpa_norm
  import fpa_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int GRD_W = 3,
  localparam int DW    = EXP_W + MAN_W + 1,
  localparam int SIG_W = MAN_W + 1 + GRD_W,
  localparam int LZ_W  = $clog2(SIG_W + 1),
  localparam int EX_W  = EXP_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              sgn_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [SIG_W:0]    sum_i,
  input  fpa_spec_t         spec_i,
  output logic              vld_o,
  output logic [DW-1:0]     res_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam logic [EXP_W-1:0] EMAX   = '1;
  localparam logic signed [EX_W-1:0] EMAX_S = EX_W'(2**EXP_W - 1);
  localparam logic [DW-1:0] QNAN = {1'b0, EMAX, 1'b1, {(MAN_W-1){1'b0}}};

  logic [LZ_W-1:0]        lz;
  logic [SIG_W-1:0]       shl;
  logic [MAN_W-1:0]       frac;
  logic signed [EX_W-1:0] e_n;
  logic [DW-1:0]          res_d;
  logic [FLAG_W-1:0]      flags_d;

  // leading-zero count over the no-carry part of the sum
  always_comb begin
    lz = LZ_W'(SIG_W);
    for (int i = 0; i < SIG_W; i++) begin
      if (sum_i[i]) lz = LZ_W'(SIG_W - 1 - i);
    end
  end

  always_comb begin
    shl = sum_i[SIG_W-1:0] << lz;
    if (sum_i[SIG_W]) begin
      frac = sum_i[SIG_W-1 -: MAN_W];
      e_n  = signed'(EX_W'(exp_i)) + EX_W'(1);
    end else begin
      frac = shl[SIG_W-2 -: MAN_W];
      e_n  = signed'(EX_W'(exp_i)) - signed'(EX_W'(lz));
    end
  end

  always_comb begin
    flags_d = '0;
    res_d   = '0;
    if (spec_i.nan) begin
      res_d           = QNAN;
      flags_d[FL_NAN] = 1'b1;
    end else if (spec_i.inf) begin
      res_d = {spec_i.inf_sgn, EMAX, {MAN_W{1'b0}}};
    end else if (sum_i == '0) begin
      flags_d[FL_ZERO] = 1'b1;
    end else if (e_n >= EMAX_S) begin
      res_d           = {sgn_i, EMAX, {MAN_W{1'b0}}};
      flags_d[FL_OVF] = 1'b1;
    end else if (e_n <= 0) begin
      flags_d[FL_UF] = 1'b1;
    end else begin
      res_d = {sgn_i, e_n[EXP_W-1:0], frac};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      res_o   <= '0;
      flags_o <= '0;
    end else begin
      vld_o   <= vld_i;
      res_o   <= vld_i ? res_d : '0;
      flags_o <= vld_i ? flags_d : '0;
    end
  end

  // R10: carry out of the top finite exponent must saturate
  p_carry_ovf_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !spec_i.nan && !spec_i.inf && sum_i[SIG_W] && exp_i == EMAX - 1'b1)
      |=> (flags_o[FL_OVF] && res_o[DW-2 -: EXP_W] == EMAX));
endmodule

// File: rtl/fp_add_pipe.sv
module fp_add_pipe
  import fpa_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int GRD_W = 3,
  localparam int DW    = EXP_W + MAN_W + 1,
  localparam int SIG_W = MAN_W + 1 + GRD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sub_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  output logic              valid_o,
  output logic [DW-1:0]     res_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic             s1_vld, s1_sgn, s1_sub;
  logic [EXP_W-1:0] s1_exp;
  logic [SIG_W-1:0] s1_big, s1_sml;
  fpa_spec_t        s1_spec;

  logic             s2_vld, s2_sgn;
  logic [EXP_W-1:0] s2_exp;
  logic [SIG_W:0]   s2_sum;
  fpa_spec_t        s2_spec;

  fpa_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRD_W(GRD_W)) i_align (
    .clk_i, .rst_ni, .valid_i, .sub_i, .a_i, .b_i,
    .vld_o(s1_vld), .sgn_o(s1_sgn), .exp_o(s1_exp), .big_o(s1_big),
    .sml_o(s1_sml), .eff_sub_o(s1_sub), .spec_o(s1_spec)
  );

  fpa_addsub #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRD_W(GRD_W)) i_addsub (
    .clk_i, .rst_ni,
    .vld_i(s1_vld), .sgn_i(s1_sgn), .exp_i(s1_exp), .big_i(s1_big),
    .sml_i(s1_sml), .eff_sub_i(s1_sub), .spec_i(s1_spec),
    .vld_o(s2_vld), .sgn_o(s2_sgn), .exp_o(s2_exp), .sum_o(s2_sum),
    .spec_o(s2_spec)
  );

  fpa_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GRD_W(GRD_W)) i_norm (
    .clk_i, .rst_ni,
    .vld_i(s2_vld), .sgn_i(s2_sgn), .exp_i(s2_exp), .sum_i(s2_sum),
    .spec_i(s2_spec),
    .vld_o(valid_o), .res_o, .flags_o
  );

  // R1: valid advances one stage per clock
  p_stage_vld_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_vld == $past(s1_vld));
  p_out_vld_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(s2_vld));
  // R7: an exact zero is always +0
  p_zero_pos_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flags_o[FL_ZERO]) |-> (res_o == '0));
  // R11: flushed results carry no sign
  p_uf_flush_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flags_o[FL_UF]) |-> (res_o == '0));
  // R13: idle output carries no data
  p_idle_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (res_o == '0 && flags_o == '0));
  p_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flags_o));
endmodule

// File: tb/test_fp_add_pipe.sv
`timescale 1ns/1ps
module test_fp_add_pipe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        sub_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        valid_o;
  logic [31:0] res_o;
  logic [3:0]  flags_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fp_add_pipe i_fp_add_pipe (
    .clk_i(clk), .rst_ni(rst_n), .valid_i, .sub_i, .a_i, .b_i,
    .valid_o, .res_o, .flags_o
  );

  task automatic cmp(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive one pair, sample when due (three rising edges after capture)
  task automatic run_op(string tag, logic [31:0] a, logic [31:0] b, logic sub,
                        logic [31:0] exp_res, logic [3:0] exp_fl);
    @(negedge clk);
    a_i = a; b_i = b; sub_i = sub; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cmp({tag, " valid"}, {31'b0, valid_o}, 32'd1);
    cmp({tag, " result"}, res_o, exp_res);
    cmp({tag, " flags"}, {28'b0, flags_o}, {28'b0, exp_fl});
  endtask

  task automatic t_reset;
    #1;
    cmp("R13 reset valid", {31'b0, valid_o}, 32'd0);
    cmp("R13 reset result", res_o, 32'h0);
    cmp("R13 reset flags", {28'b0, flags_o}, 32'h0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R13 idle after reset", {31'b0, valid_o}, 32'd0);
  endtask

  task automatic t_add;
    run_op("R2 1+1", 32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 4'h0);
    run_op("R2 1.5+2.5", 32'h3FC00000, 32'h40200000, 1'b0, 32'h40800000, 4'h0);
    run_op("R2 truncate", 32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800000, 4'h0);
    run_op("R2 neg+neg", 32'hBF800000, 32'hC0000000, 1'b0, 32'hC0400000, 4'h0);
  endtask

  task automatic t_sub;
    run_op("R3 3-1", 32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, 4'h0);
    run_op("R3 0-1", 32'h00000000, 32'h3F800000, 1'b1, 32'hBF800000, 4'h0);
    run_op("R3 1+(-3)", 32'h3F800000, 32'hC0400000, 1'b0, 32'hC0000000, 4'h0);
    run_op("R3 1-(-1)", 32'h3F800000, 32'hBF800000, 1'b1, 32'h40000000, 4'h0);
  endtask

  task automatic t_align;
    run_op("R4 far below", 32'h3F800000, 32'h0D800000, 1'b0, 32'h3F800000, 4'h0);
    run_op("R4 small first", 32'h3F000000, 32'h41000000, 1'b0, 32'h41080000, 4'h0);
  endtask

  task automatic t_carry;
    run_op("R5 carry trunc", 32'h3FFFFFFF, 32'h3F800000, 1'b0, 32'h403FFFFF, 4'h0);
  endtask

  task automatic t_cancel;
    run_op("R6 1.5-1.25", 32'h3FC00000, 32'h3FA00000, 1'b1, 32'h3E800000, 4'h0);
    run_op("R6 1.25-1.5", 32'h3FA00000, 32'h3FC00000, 1'b1, 32'hBE800000, 4'h0);
  endtask

  task automatic t_zero;
    run_op("R7 1-1", 32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 4'h8);
    run_op("R7 -1+1", 32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, 4'h8);
    run_op("R7 -0+-0", 32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 4'h8);
  endtask

  task automatic t_nan;
    run_op("R8 nan a", 32'h7FC00001, 32'h3F800000, 1'b0, 32'h7FC00000, 4'h1);
    run_op("R8 nan b", 32'h3F800000, 32'hFF800001, 1'b1, 32'h7FC00000, 4'h1);
  endtask

  task automatic t_inf;
    run_op("R9 inf+1", 32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 4'h0);
    run_op("R9 1-inf", 32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 4'h0);
    run_op("R9 inf-inf", 32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 4'h1);
  endtask

  task automatic t_ovf;
    run_op("R10 pos ovf", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 4'h2);
    run_op("R10 neg ovf", 32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, 4'h2);
  endtask

  task automatic t_uf;
    run_op("R11 flush", 32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 4'h4);
    run_op("R11 neg flush", 32'h80800000, 32'h80800001, 1'b1, 32'h00000000, 4'h4);
  endtask

  task automatic t_denorm;
    run_op("R12 denorm+1", 32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, 4'h0);
    run_op("R12 denorm-denorm", 32'h00000005, 32'h00000003, 1'b1, 32'h00000000, 4'h8);
  endtask

  task automatic t_stream;
    @(negedge clk);
    a_i = 32'h3F800000; b_i = 32'h3F800000; sub_i = 1'b0; valid_i = 1'b1;
    @(negedge clk);
    a_i = 32'h40400000; b_i = 32'h3F800000; sub_i = 1'b1;
    @(negedge clk);
    cmp("R1 not early", {31'b0, valid_o}, 32'd0);
    a_i = 32'h7F800000; b_i = 32'h3F800000; sub_i = 1'b0;
    @(negedge clk);
    valid_i = 1'b0;
    cmp("R1 first valid", {31'b0, valid_o}, 32'd1);
    cmp("R1 first result", res_o, 32'h40000000);
    @(negedge clk);
    cmp("R1 second valid", {31'b0, valid_o}, 32'd1);
    cmp("R1 second result", res_o, 32'h40000000);
    @(negedge clk);
    cmp("R1 third valid", {31'b0, valid_o}, 32'd1);
    cmp("R1 third result", res_o, 32'h7F800000);
    @(negedge clk);
    cmp("R1 bubble", {31'b0, valid_o}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_align();
    t_carry();
    t_cancel();
    t_zero();
    t_nan();
    t_inf();
    t_ovf();
    t_uf();
    t_denorm();
    t_stream();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule